// File: doc/BRIEF.md
# Single-Scan Trigger Status Controller

This block holds one armed/idle status bit for each command queue that may run in single-scan mode. Software arms a queue by writing a 1 to a separate scan-enable control bit. The status bit itself cannot be written. Hardware drops the bit again on three events: a command that carries the end-of-queue marker is transferred from a queue in a single-scan mode; a queue in level-gated single-scan mode leaves its triggered state because its gate has closed; or the queue's mode field is switched to disabled.

The bit is qualified by the current queue mode, which gives two outputs. In software-triggered single-scan mode the bit acts directly as the trigger. In level-gated and edge-triggered single-scan modes it enables the external trigger detectors. In continuous or disabled mode it has no effect. Changes to the mode are found by comparing the mode field with a registered copy from the previous cycle. All queues are independent slices of one parameterised structure.

Top module: `scan_arm_ctrl`

## Requirements
- R1: A pulse on `arm_wr[q]` with no clear event for queue q sets `sss[q]` on the next clock edge, in any mode. There is no other way to set it.
- R2: A pulse on `xfer_eoq[q]` while the mode of q is a single-scan code (1 software, 2 level, 3 edge) clears `sss[q]` on the next edge. The same pulse in mode 0 or in modes 4 to 7 leaves the bit unchanged.
- R3: A pulse on `gate_closed[q]` in mode 2 clears `sss[q]` on the next edge. The same pulse in any other mode leaves the bit unchanged.
- R4: A cycle in which the mode of q becomes 0 (disabled) after a cycle with a different value clears `sss[q]`. A mode that stays at 0 does not clear it, so an arm write while the mode stays disabled sets the bit.
- R5: When a clear event and an arm write occur for the same queue in the same cycle, the bit ends cleared.
- R6: `sw_trig[q]` is 1 exactly when `sss[q]` is 1 and the mode of q is 1.
- R7: `det_en[q]` is 1 exactly when `sss[q]` is 1 and the mode of q is 2 or 3.
- R8: In mode 0 and in modes 4 to 7 (codes 5 to 7 behave as continuous mode 4), both `sw_trig[q]` and `det_en[q]` are 0 whatever the value of `sss[q]`. A bit that is set stays set in continuous mode.
- R9: While `rst_n` is low, every `sss` bit is 0 and the registered previous mode of every queue is 0.
- R10: Events on one queue never change the status or outputs of any other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_mode | input | NQ*3 | Mode field per queue; queue q at bits [3q+2:3q] |
| arm_wr | input | NQ | One-cycle strobe: a 1 was written to the scan-enable bit of queue q |
| xfer_eoq | input | NQ | One-cycle strobe: a command with the end-of-queue marker left queue q |
| gate_closed | input | NQ | One-cycle strobe: queue q left its triggered state on a closed level gate |
| sss | output | NQ | Single-scan status bit per queue |
| sw_trig | output | NQ | Software trigger per queue (software single-scan mode) |
| det_en | output | NQ | Trigger detection enable per queue (level or edge single-scan mode) |

## Verification
The bench builds the block with six queues instead of the default four. This lets the random phase keep several queues in different modes at once, and the reserved mode codes get exercised next to the defined ones. With six slices, independence between queues (R10) can be seen while a neighbour is being armed, cleared or switched off. A bench reference model predicts the status bit and both qualified outputs of every queue on every cycle. Directed cases cover simultaneous arm-and-clear, events in modes where they must be ignored, and arming while the mode stays disabled.

// File: rtl/sac_pkg.sv
// Package: shared mode encoding and helpers for the single-scan status controller.
// Assumes a 3-bit mode field per queue; codes 5..7 behave as continuous scan.
package sac_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        QM_OFF  = 3'd0,
        QM_SW   = 3'd1,
        QM_LVL  = 3'd2,
        QM_EDGE = 3'd3,
        QM_CONT = 3'd4
    } qmode_e;

    // True for the three single-scan variants.
    function automatic logic mode_is_single(input logic [MODE_W-1:0] m);
        return (m == QM_SW) || (m == QM_LVL) || (m == QM_EDGE);
    endfunction

    // True for the two variants that use external trigger detection.
    function automatic logic mode_is_detect(input logic [MODE_W-1:0] m);
        return (m == QM_LVL) || (m == QM_EDGE);
    endfunction

endpackage

// File: rtl/sac_mode_watch.sv
// Module: sac_mode_watch
// Keeps a registered copy of one queue's mode field and flags the cycle in
// which the field becomes disabled. Assumes the mode input is synchronous to clk.
module sac_mode_watch
    import sac_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_i,
    output logic          to_off_o
);

    logic [MW-1:0] prev_q;

    // Purpose: remember the mode seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= MW'(QM_OFF);
        end else begin
            prev_q <= mode_i;
        end
    end

    // Purpose: flag a transition into the disabled code.
    always_comb begin
        to_off_o = (mode_i == MW'(QM_OFF)) && (prev_q != MW'(QM_OFF));
    end

endmodule

// File: rtl/sac_clear_dec.sv
// Module: sac_clear_dec
// Combines the three hardware clear sources of one queue into a single request.
// Assumes event strobes are one-cycle pulses aligned with the current mode.
module sac_clear_dec
    import sac_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode_i,
    input  logic          eoq_i,
    input  logic          gate_i,
    input  logic          to_off_i,
    output logic          clr_o
);

    logic eoq_hit;
    logic gate_hit;

    // Purpose: qualify each clear source by the mode it applies to.
    always_comb begin
        eoq_hit  = eoq_i && mode_is_single(mode_i);
        gate_hit = gate_i && (mode_i == MW'(QM_LVL));
        clr_o    = eoq_hit || gate_hit || to_off_i;
    end

endmodule

// File: rtl/sac_status_cell.sv
// Module: sac_status_cell
// One status flop: set by an arm write, cleared by a clear request; clear wins.
module sac_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clr_i,
    output logic stat_o
);

    // Purpose: update the status bit with clear priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= 1'b0;
        end else if (clr_i) begin
            stat_o <= 1'b0;
        end else if (arm_i) begin
            stat_o <= 1'b1;
        end
    end

endmodule

// File: rtl/sac_trig_qual.sv
// Module: sac_trig_qual
// Turns the status bit into a software trigger or a detector enable, depending
// on the current mode. Continuous, disabled and reserved codes give neither.
module sac_trig_qual
    import sac_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode_i,
    input  logic          stat_i,
    output logic          sw_trig_o,
    output logic          det_en_o
);

    // Purpose: route the status bit to the output that matches the mode.
    always_comb begin
        sw_trig_o = stat_i && (mode_i == MW'(QM_SW));
        det_en_o  = stat_i && mode_is_detect(mode_i);
    end

endmodule

// File: rtl/scan_arm_ctrl.sv
// Module: scan_arm_ctrl (top)
// Per-queue single-scan status bits with their mode-qualified trigger outputs.
// Assumes all strobes are synchronous one-cycle pulses; queue q's mode sits in
// q_mode[q*MW +: MW].
module scan_arm_ctrl
    import sac_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NQ*MODE_W-1:0] q_mode,
    input  logic [NQ-1:0]        arm_wr,
    input  logic [NQ-1:0]        xfer_eoq,
    input  logic [NQ-1:0]        gate_closed,
    output logic [NQ-1:0]        sss,
    output logic [NQ-1:0]        sw_trig,
    output logic [NQ-1:0]        det_en
);

    localparam int MW = MODE_W;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic [MW-1:0] mode_q;
        logic          to_off;
        logic          clr;

        assign mode_q = q_mode[q*MW +: MW];

        sac_mode_watch #(.MW(MW)) u_watch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (mode_q),
            .to_off_o (to_off)
        );

        sac_clear_dec #(.MW(MW)) u_clr (
            .mode_i   (mode_q),
            .eoq_i    (xfer_eoq[q]),
            .gate_i   (gate_closed[q]),
            .to_off_i (to_off),
            .clr_o    (clr)
        );

        sac_status_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (arm_wr[q]),
            .clr_i  (clr),
            .stat_o (sss[q])
        );

        sac_trig_qual #(.MW(MW)) u_qual (
            .mode_i    (mode_q),
            .stat_i    (sss[q]),
            .sw_trig_o (sw_trig[q]),
            .det_en_o  (det_en[q])
        );
    end

endmodule

// File: rtl/sac_checker.sv
// Module: sac_checker
// Port-level properties of scan_arm_ctrl, bound to every instance of the top.
module sac_checker
    import sac_pkg::*;
#(
    parameter int NQ = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NQ*MODE_W-1:0] q_mode,
    input logic [NQ-1:0]        arm_wr,
    input logic [NQ-1:0]        xfer_eoq,
    input logic [NQ-1:0]        gate_closed,
    input logic [NQ-1:0]        sss,
    input logic [NQ-1:0]        sw_trig,
    input logic [NQ-1:0]        det_en
);

    localparam int MW = MODE_W;

    logic past_ok;

    // Purpose: mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        logic [MW-1:0] m;
        logic          ss_mode;
        logic          lvl_mode;
        assign m        = q_mode[q*MW +: MW];
        assign ss_mode  = (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
        assign lvl_mode = (m == 3'd2);

        AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_wr[q] && m != 3'd0 && !(xfer_eoq[q] && ss_mode) && !(gate_closed[q] && lvl_mode))
            |=> sss[q]); // R1
        AST_EOQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_eoq[q] && ss_mode) |=> !sss[q]); // R2
        AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_closed[q] && lvl_mode) |=> !sss[q]); // R3
        AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && m == 3'd0 && $past(q_mode[q*MW +: MW]) != 3'd0) |=> !sss[q]); // R4
        AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!arm_wr[q] && m != 3'd0 && !(xfer_eoq[q] && ss_mode) && !(gate_closed[q] && lvl_mode))
            |=> $stable(sss[q])); // R2
        AST_SW_TRIG_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
            sw_trig[q] |-> (sss[q] && m == 3'd1)); // R6
        AST_DET_EN_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
            det_en[q] |-> (sss[q] && (m == 3'd2 || m == 3'd3))); // R7
        AST_IDLE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd0 || m >= 3'd4) |-> (!sw_trig[q] && !det_en[q])); // R8
    end

endmodule

bind scan_arm_ctrl sac_checker #(.NQ(NQ)) u_sac_checker (.*);

// File: tb/tb_scan_arm_ctrl.sv
module tb_scan_arm_ctrl;
    import sac_pkg::*;

    localparam int NQ     = 6;
    localparam int MW     = MODE_W;
    localparam int CLK_NS = 10;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NQ*MW-1:0]     q_mode;
    logic [NQ-1:0]        arm_wr, xfer_eoq, gate_closed;
    logic [NQ-1:0]        sss, sw_trig, det_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [NQ-1:0] exp_sss;
    logic [MW-1:0] exp_prev [NQ];

    always #(CLK_NS/2) clk = ~clk;

    scan_arm_ctrl #(.NQ(NQ)) dut (
        .clk(clk), .rst_n(rst_n), .q_mode(q_mode), .arm_wr(arm_wr),
        .xfer_eoq(xfer_eoq), .gate_closed(gate_closed),
        .sss(sss), .sw_trig(sw_trig), .det_en(det_en)
    );

    function automatic logic [MW-1:0] gm(int q);
        return q_mode[q*MW +: MW];
    endfunction

    function automatic logic is_ss(logic [MW-1:0] m);
        return (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
    endfunction

    // Next status value from the requirements (R1..R5).
    function automatic logic model_next(logic cur, logic arm, logic eoq, logic gate,
                                        logic [MW-1:0] m, logic [MW-1:0] p);
        logic clr;
        clr = (eoq && is_ss(m)) || (gate && m == 3'd2) || (m == 3'd0 && p != 3'd0);
        if (clr) return 1'b0;
        if (arm) return 1'b1;
        return cur;
    endfunction

    task automatic set_mode(int q, logic [MW-1:0] m);
        q_mode[q*MW +: MW] = m;
    endtask

    task automatic check_q(int q, string tag);
        logic e_sw, e_det;
        e_sw  = exp_sss[q] && gm(q) == 3'd1;
        e_det = exp_sss[q] && (gm(q) == 3'd2 || gm(q) == 3'd3);
        n_cmp++;
        if (sss[q] !== exp_sss[q] || sw_trig[q] !== e_sw || det_en[q] !== e_det) begin
            n_bad++;
            $display("FAIL %s q%0d: sss/sw/det actual %b%b%b expected %b%b%b",
                     tag, q, sss[q], sw_trig[q], det_en[q], exp_sss[q], e_sw, e_det);
        end
    endtask

    task automatic check_all(string tag);
        for (int q = 0; q < NQ; q++) check_q(q, tag);
    endtask

    // Advance one clock, updating the reference model with the driven inputs.
    task automatic tick();
        @(posedge clk);
        for (int q = 0; q < NQ; q++) begin
            if (!rst_n) begin
                exp_sss[q]  = 1'b0;
                exp_prev[q] = '0;
            end else begin
                exp_sss[q]  = model_next(exp_sss[q], arm_wr[q], xfer_eoq[q],
                                         gate_closed[q], gm(q), exp_prev[q]);
                exp_prev[q] = gm(q);
            end
        end
        @(negedge clk);
        arm_wr = '0; xfer_eoq = '0; gate_closed = '0;
        #1;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5AC1_0042));
        rst_n = 1'b0; q_mode = '0; arm_wr = '0; xfer_eoq = '0; gate_closed = '0;
        exp_sss = '0;
        for (int q = 0; q < NQ; q++) exp_prev[q] = '0;
        repeat (3) tick();
        check_all("R9 in reset");
        rst_n = 1'b1;
        tick();
        check_all("R9 after reset");

        // R1 / R6: software single-scan arm on q0.
        set_mode(0, 3'd1); arm_wr[0] = 1'b1; tick();
        check_q(0, "R1 arm sets"); check_q(0, "R6 sw trigger");
        check_all("R10 neighbours untouched");

        // R5 / R2: end-of-queue with simultaneous arm clears q0.
        arm_wr[0] = 1'b1; xfer_eoq[0] = 1'b1; tick();
        check_q(0, "R5 clear beats arm");

        // R7 / R3: level mode on q1, then a closed gate.
        set_mode(1, 3'd2); arm_wr[1] = 1'b1; tick();
        check_q(1, "R7 level detect enable");
        gate_closed[1] = 1'b1; tick();
        check_q(1, "R3 gate clears in level");

        // R8 / R2 / R3: continuous mode keeps the bit, ignores events.
        set_mode(2, 3'd4); arm_wr[2] = 1'b1; tick();
        check_q(2, "R8 continuous quiet");
        xfer_eoq[2] = 1'b1; tick();
        check_q(2, "R2 eoq ignored in continuous");
        gate_closed[2] = 1'b1; tick();
        check_q(2, "R3 gate ignored in continuous");

        // R4: change to disabled clears; arming while disabled holds.
        set_mode(2, 3'd0); tick();
        check_q(2, "R4 change to disabled clears");
        arm_wr[2] = 1'b1; tick();
        check_q(2, "R4 arm while disabled");
        check_q(2, "R8 disabled quiet");

        // R7 / R3 / R10: edge mode on q3, gate pulse has no effect there.
        set_mode(3, 3'd3); arm_wr[3] = 1'b1; tick();
        check_q(3, "R7 edge detect enable");
        gate_closed[3] = 1'b1; tick();
        check_q(3, "R3 gate ignored in edge");
        xfer_eoq[3] = 1'b1; tick();
        check_q(3, "R2 eoq clears in edge");
        check_all("R10 independence");

        // Random phase.
        for (int it = 0; it < 3000; it++) begin
            for (int q = 0; q < NQ; q++) begin
                if ($urandom_range(7) == 0) set_mode(q, MW'($urandom_range(7)));
                arm_wr[q]      = ($urandom_range(3) == 0);
                xfer_eoq[q]    = ($urandom_range(5) == 0);
                gate_closed[q] = ($urandom_range(5) == 0);
            end
            tick();
            check_all("R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule